// File: doc/BRIEF.md
# Sync-Gated Transparent Serial Channel

This block is a transmitter and receiver pair for unframed serial data. Both directions run on one serial clock and move characters of a programmable length, least-significant bit first. After a direction is enabled it stays idle until a synchronization event arrives. Only then does it start shifting characters on fixed character boundaries. The transmitter drives ones while it waits, and the receiver ignores its input line while it waits.

The synchronization event comes from one of two sources, picked by a mode input. In pin mode it is a falling edge on an active-low sync line, so one edge can align both directions at once. In slot mode each direction has its own strobe, which marks that direction's first active time slot after a frame sync. The two directions can therefore be enabled together and still align at different times. Either direction can be realigned by clearing and setting its enable. The receiver can also be realigned with a hunt command.

The transmit side holds one pending character behind a valid/ready handshake. The receive side presents each finished character with a one-cycle valid pulse.

Top module: `sync_serial_chan`

## Requirements
- R1: After reset, txd is 1, tx_ready is 1 and rx_valid is 0.
- R2: A transmitter that is disabled, or enabled but not yet aligned, drives txd to 1 in every cycle, even when a character is pending.
- R3: In pin mode (mode_slot = 0), the event is a cycle in which sync_n is sampled 0 after being sampled 1 in the previous cycle. The event counts only for a direction that is enabled and not yet aligned. Further falling edges while a direction is aligned have no effect, and one edge aligns both directions when both are waiting.
- R4: Once aligned, the transmitter puts bit 0 of a character on txd in the cycle after the event. Bits 1 to char_len-1 follow in the next cycles, and characters follow one another with no gap.
- R5: If no character is pending at the event or at a character boundary, the transmitter sends char_len ones. A character accepted during that group starts at the next boundary.
- R6: A character is accepted when tx_valid and tx_ready are both 1. This happens whether or not the transmitter is enabled. tx_ready is then 0 until the character moves into the shifter, which happens at an event or at a character boundary.
- R7: For an aligned receiver, the rxd bit sampled in the cycle after the event is bit 0 of the first character. After char_len bits, rx_data holds bit i in position i, with zeros above char_len-1. rx_valid is 1 for the single cycle that follows the last bit.
- R8: A hunt pulse drops receive alignment and discards the partial character. No character is output until the next event, and the bit sampled after that event is bit 0.
- R9: Clearing an enable makes that direction unaligned from the next cycle. txd returns to 1 at once, and the receiver emits no further characters. After the enable is set again, the next event realigns the direction.
- R10: In slot mode (mode_slot = 1), slot_tx is the event for the transmitter and slot_rx is the event for the receiver. sync_n is ignored, and each direction aligns only on its own strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock; all sampling and shifting happen on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_slot | input | 1 | Event source: 0 = sync line falling edge, 1 = per-direction slot strobes |
| sync_n | input | 1 | External active-low sync line |
| slot_tx | input | 1 | First-slot strobe for the transmitter |
| slot_rx | input | 1 | First-slot strobe for the receiver |
| char_len | input | LEN_W | Character length in bits, 1 to MAX_LEN |
| tx_en | input | 1 | Transmitter enable |
| rx_en | input | 1 | Receiver enable |
| hunt | input | 1 | One-cycle command that drops receive alignment |
| tx_data | input | MAX_LEN | Character to transmit, LSB sent first |
| tx_valid | input | 1 | tx_data is valid |
| tx_ready | output | 1 | The one-character holding slot is empty |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |
| rx_data | output | MAX_LEN | Last received character |
| rx_valid | output | 1 | One-cycle pulse when rx_data is updated |

## Verification
The embedded assertions check, on every cycle, the properties that need no long history:
- txd goes high in the cycle after the transmit enable is low.
- tx_ready drops after a handshake and rises only while enabled.
- No character follows a hunt pulse.
- rx_valid is seen only when the receiver was enabled.

The scenarios cover everything that depends on when an event lands. This includes the exact bit order on txd and rxd relative to the event, and the group of ones sent when no character is pending. They also show that a second edge or a wrong strobe changes nothing, that realignment after a hunt or a re-enable works, and that slot mode keeps the two directions apart.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
    typedef enum logic {
        MODE_PIN  = 1'b0,
        MODE_SLOT = 1'b1
    } sync_mode_e;

    localparam int DIR_TX = 0;
    localparam int DIR_RX = 1;
    localparam int N_DIR  = 2;
endpackage

// File: rtl/ssc_sync_gen.sv
module ssc_sync_gen
    import ssc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_slot,
    input  logic             sync_n,
    input  logic [N_DIR-1:0] slot_strobe,
    output logic [N_DIR-1:0] event_o
);
    typedef struct packed {
        logic prev;
    } sg_state_t;

    sg_state_t  st_d, st_q;
    logic       pin_fall;
    sync_mode_e mode;

    always_comb begin
        st_d      = st_q;
        st_d.prev = sync_n;
        mode      = sync_mode_e'(mode_slot);
        pin_fall  = st_q.prev & ~sync_n;
    end

    for (genvar g = 0; g < N_DIR; g++) begin : g_dir
        assign event_o[g] = (mode == MODE_SLOT) ? slot_strobe[g] : pin_fall;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{prev: 1'b1};
        else        st_q <= st_d;
    end
endmodule

// File: rtl/ssc_tx.sv
module ssc_tx #(
    parameter int MAXL = 16,
    parameter int LW   = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            sync_ev,
    input  logic [LW-1:0]   char_len,
    input  logic [MAXL-1:0] tx_data,
    input  logic            tx_valid,
    output logic            tx_ready,
    output logic            txd
);
    typedef struct packed {
        logic            synced;
        logic [LW-1:0]   cnt;
        logic [MAXL-1:0] shreg;
        logic [MAXL-1:0] hold;
        logic            hold_v;
    } tx_state_t;

    tx_state_t   st_d, st_q;
    logic [LW-1:0] lim;
    logic          last_bit;
    logic          load;
    logic          take;

    always_comb begin
        st_d     = st_q;
        lim      = char_len - LW'(1);
        last_bit = (st_q.cnt == lim);
        load     = 1'b0;
        take     = tx_valid & ~st_q.hold_v;

        if (take) begin
            st_d.hold   = tx_data;
            st_d.hold_v = 1'b1;
        end

        if (!en) begin
            st_d.synced = 1'b0;
        end else if (!st_q.synced) begin
            if (sync_ev) begin
                st_d.synced = 1'b1;
                load        = 1'b1;
            end
        end else if (last_bit) begin
            load = 1'b1;
        end else begin
            st_d.shreg = {1'b1, st_q.shreg[MAXL-1:1]};
            st_d.cnt   = st_q.cnt + LW'(1);
        end

        if (load) begin
            st_d.cnt = '0;
            if (st_q.hold_v) begin
                st_d.shreg  = st_q.hold;
                st_d.hold_v = 1'b0;
            end else begin
                st_d.shreg = '1;
            end
        end
    end

    assign tx_ready = ~st_q.hold_v;
    assign txd      = st_q.synced ? st_q.shreg[0] : 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{synced: 1'b0, cnt: '0, shreg: '1, hold: '0, hold_v: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    a_r9_tx_off_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> txd);
    a_r6_take_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> !tx_ready);
    a_r6_ready_rise_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_ready) |-> $past(en));
endmodule

// File: rtl/ssc_rx.sv
module ssc_rx #(
    parameter int MAXL = 16,
    parameter int LW   = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            hunt,
    input  logic            sync_ev,
    input  logic [LW-1:0]   char_len,
    input  logic            rxd,
    output logic [MAXL-1:0] rx_data,
    output logic            rx_valid
);
    typedef struct packed {
        logic            synced;
        logic [LW-1:0]   cnt;
        logic [MAXL-1:0] acc;
        logic [MAXL-1:0] out;
        logic            vld;
    } rx_state_t;

    rx_state_t       st_d, st_q;
    logic [LW-1:0]   lim;
    logic [MAXL-1:0] merged;

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        lim      = char_len - LW'(1);
        merged   = st_q.acc | ({{(MAXL-1){1'b0}}, rxd} << st_q.cnt);

        if (!en || hunt) begin
            st_d.synced = 1'b0;
        end else if (!st_q.synced) begin
            if (sync_ev) begin
                st_d.synced = 1'b1;
                st_d.cnt    = '0;
                st_d.acc    = '0;
            end
        end else if (st_q.cnt == lim) begin
            st_d.out = merged;
            st_d.vld = 1'b1;
            st_d.cnt = '0;
            st_d.acc = '0;
        end else begin
            st_d.acc = merged;
            st_d.cnt = st_q.cnt + LW'(1);
        end
    end

    assign rx_data  = st_q.out;
    assign rx_valid = st_q.vld;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{synced: 1'b0, cnt: '0, acc: '0, out: '0, vld: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    a_r8_hunt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        hunt |=> !rx_valid);
    a_r9_rx_valid_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(en));
endmodule

// File: rtl/sync_serial_chan.sv
module sync_serial_chan
    import ssc_pkg::*;
#(
    parameter int MAX_LEN = 16,
    parameter int LEN_W   = $clog2(MAX_LEN + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mode_slot,
    input  logic               sync_n,
    input  logic               slot_tx,
    input  logic               slot_rx,
    input  logic [LEN_W-1:0]   char_len,
    input  logic               tx_en,
    input  logic               rx_en,
    input  logic               hunt,
    input  logic [MAX_LEN-1:0] tx_data,
    input  logic               tx_valid,
    output logic               tx_ready,
    output logic               txd,
    input  logic               rxd,
    output logic [MAX_LEN-1:0] rx_data,
    output logic               rx_valid
);
    logic [N_DIR-1:0] strobes;
    logic [N_DIR-1:0] events;

    assign strobes[DIR_TX] = slot_tx;
    assign strobes[DIR_RX] = slot_rx;

    ssc_sync_gen u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_slot  (mode_slot),
        .sync_n     (sync_n),
        .slot_strobe(strobes),
        .event_o    (events)
    );

    ssc_tx #(.MAXL(MAX_LEN), .LW(LEN_W)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (tx_en),
        .sync_ev (events[DIR_TX]),
        .char_len(char_len),
        .tx_data (tx_data),
        .tx_valid(tx_valid),
        .tx_ready(tx_ready),
        .txd     (txd)
    );

    ssc_rx #(.MAXL(MAX_LEN), .LW(LEN_W)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (rx_en),
        .hunt    (hunt),
        .sync_ev (events[DIR_RX]),
        .char_len(char_len),
        .rxd     (rxd),
        .rx_data (rx_data),
        .rx_valid(rx_valid)
    );
endmodule

// File: tb/sync_serial_chan_tb_top.sv
module sync_serial_chan_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int MAX_LEN    = 16;
    localparam int LEN_W      = $clog2(MAX_LEN + 1);

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               mode_slot = 1'b0;
    logic               sync_n = 1'b1;
    logic               slot_tx = 1'b0;
    logic               slot_rx = 1'b0;
    logic [LEN_W-1:0]   char_len = LEN_W'(5);
    logic               tx_en = 1'b0;
    logic               rx_en = 1'b0;
    logic               hunt = 1'b0;
    logic [MAX_LEN-1:0] tx_data = '0;
    logic               tx_valid = 1'b0;
    logic               tx_ready;
    logic               txd;
    logic               rxd = 1'b1;
    logic [MAX_LEN-1:0] rx_data;
    logic               rx_valid;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;
    logic [MAX_LEN-1:0] exp_q[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    sync_serial_chan #(.MAX_LEN(MAX_LEN)) dut_i (
        .clk(clk), .rst_n(rst_n), .mode_slot(mode_slot), .sync_n(sync_n),
        .slot_tx(slot_tx), .slot_rx(slot_rx), .char_len(char_len),
        .tx_en(tx_en), .rx_en(rx_en), .hunt(hunt), .tx_data(tx_data),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .txd(txd), .rxd(rxd),
        .rx_data(rx_data), .rx_valid(rx_valid)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Receive monitor: pops the scoreboard on every rx_valid pulse (R7)
    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            if (exp_q.size() == 0) begin
                check("R7 unexpected character", 32'(rx_data), 32'hDEAD);
            end else begin
                check("R7 received character", 32'(rx_data), 32'(exp_q.pop_front()));
            end
        end
    end

    task automatic push_tx(logic [MAX_LEN-1:0] d);
        tx_data  = d;
        tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
    endtask

    // One iteration per cycle; drives applied at iteration i take effect at the next rising edge
    task automatic run(int n, string req, bit chk_tx, logic [63:0] txexp, logic [63:0] rxv,
                       int sync_a, int sync_b, int srx, int stx, int hunt_at,
                       int push_at, logic [MAX_LEN-1:0] push_data);
        for (int i = 0; i < n; i++) begin
            if (chk_tx) check(req, 32'(txd), 32'(txexp[i]));
            rxd      = rxv[i];
            sync_n   = !(i == sync_a || i == sync_b);
            slot_rx  = (i == srx);
            slot_tx  = (i == stx);
            hunt     = (i == hunt_at);
            tx_valid = (i == push_at);
            tx_data  = push_data;
            @(negedge clk);
        end
        sync_n = 1'b1; slot_rx = 1'b0; slot_tx = 1'b0; hunt = 1'b0; tx_valid = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 txd reset", 32'(txd), 32'd1);
        check("R1 tx_ready reset", 32'(tx_ready), 32'd1);
        check("R1 rx_valid reset", 32'(rx_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // S1: pin mode, both enabled together, length 5, preloaded character
        char_len = LEN_W'(5);
        push_tx(16'h0016);
        check("R6 ready low while holding", 32'(tx_ready), 32'd0);
        tx_en = 1'b1; rx_en = 1'b1;
        exp_q.push_back(16'h000B);
        exp_q.push_back(16'h0013);
        exp_q.push_back(16'h001F);
        run(20, "R2 R3 R4 tx stream", 1'b1, ~64'h120, ~64'h3280, 4, 11, -1, -1, -1, -1, '0);
        check("R6 ready after load", 32'(tx_ready), 32'd1);
        tx_en = 1'b0; rx_en = 1'b0;
        @(negedge clk);

        // S2: nothing pending at the event, character arrives during ones group
        tx_en = 1'b1;
        run(15, "R5 ones group then data", 1'b1, ~64'h680, '1, 0, -1, -1, -1, -1, 2, 16'h0005);
        check("R6 ready empty after S2", 32'(tx_ready), 32'd1);

        // S3: disable mid character, then realign on a later edge
        tx_en = 1'b0;
        @(negedge clk);
        push_tx(16'h0000);
        tx_en = 1'b1;
        run(3, "R4 zero char start", 1'b1, ~64'h6, '1, 0, -1, -1, -1, -1, -1, '0);
        check("R4 zero bit in flight", 32'(txd), 32'd0);
        tx_en = 1'b0;
        @(negedge clk);
        check("R9 txd idle after disable", 32'(txd), 32'd1);
        push_tx(16'h000D);
        check("R2 disabled with pending char", 32'(txd), 32'd1);
        tx_en = 1'b1;
        run(9, "R9 realign after re-enable", 1'b1, ~64'h120, '1, 3, -1, -1, -1, -1, -1, '0);
        tx_en = 1'b0;
        @(negedge clk);

        // S4: hunt drops receive alignment, length 8
        char_len = LEN_W'(8);
        rx_en = 1'b1;
        run(7, "R8", 1'b0, '1, 64'h55, 0, -1, -1, -1, -1, -1, '0);
        run(1, "R8", 1'b0, '1, 64'h0, -1, -1, -1, -1, 0, -1, '0);
        exp_q.push_back(16'h00A5);
        run(12, "R8 realign after hunt", 1'b0, '1, (64'hA5 << 4) | 64'h7, 3, -1, -1, -1, -1, -1, '0);
        rx_en = 1'b0;
        @(negedge clk);

        // S5: slot mode, both enabled together, separate alignment, length 4
        mode_slot = 1'b1;
        char_len = LEN_W'(4);
        push_tx(16'h0009);
        tx_en = 1'b1; rx_en = 1'b1;
        exp_q.push_back(16'h0006);
        exp_q.push_back(16'h0003);
        run(14, "R10 slot tx alignment", 1'b1, ~64'hC00, ~64'hC90, 1, -1, 3, 8, -1, -1, '0);
        tx_en = 1'b0; rx_en = 1'b0;
        repeat (2) @(negedge clk);

        check("R7 R8 R10 all expected characters seen", 32'(exp_q.size()), 32'd0);
        finish_run();
    end
endmodule